// File: doc/BRIEF.md
# Serial Flash Erase Command Decoder

This block is the device-side command front end for erase operations of a serial flash. It acts as an SPI mode-0 slave: while chip select is low it samples the data input on each rising edge of the serial clock, most significant bit first, and assembles bytes. All serial inputs are sampled and edge-detected in the local clock domain. The serial clock must therefore be slow compared with `clk_i`.

When chip select is released, the block checks what was received. It accepts either a sector erase (one opcode byte plus a three-byte address) or a four-byte chip erase sequence. For a sector erase it derives the target erase unit under either of two page-size layouts. It then emits a one-cycle erase request carrying a 17-bit unit mask that has already been filtered through the protection mask. Sector 0 is split into two erase units, so there are 17 units.

After a request, `busy_o` stays high for a parameterised number of cycles. This stands in for the self-timed erase. Sector erase and chip erase have separate durations.

Top module: `flash_erase_decoder`

## Requirements
- R1: After reset, `erase_req_o` and `busy_o` are low and `erase_mask_o` is zero. Whenever `erase_req_o` is low, `erase_mask_o` is zero.
- R2: With `page_bin_i`=0, a sector erase is opcode 0x7C followed by three address bytes, MSB first. Address bits [20:17] name the sector, and sectors 1..15 map to mask bit sector+1. Bits [23:21] and [8:0] have no effect.
- R3: With `page_bin_i`=1, address bits [19:16] name the sector, and sectors 1..15 map to mask bit sector+1. Bits [23:20] and [10:0] have no effect.
- R4: Sector 0 is split by the page offset inside it: pages 0..7 are sub-sector a (mask bit 0), and pages 8..255 are sub-sector b (mask bit 1). The page offset is bits [16:12] in 264-byte mode and bits [15:11] in binary mode; a value of zero selects sub-sector a.
- R5: A request is issued only after chip select rises, as a single-cycle pulse about two clock cycles after the rise. A sector erase request has exactly one mask bit set and `erase_chip_o` low.
- R6: A chip erase is the bytes 0xC7, 0x94, 0x80, 0x9A with no address. Further bytes or bits sent before chip select rises are ignored. The request has `erase_chip_o` high and a mask equal to the inverse of `prot_i`.
- R7: A command is discarded with no request and no busy period if it has a wrong opcode, a wrong chip erase byte, fewer than four bytes, more than four bytes for a sector erase, or a sector erase whose bit count is not a whole number of bytes.
- R8: A sector erase to a unit whose `prot_i` bit is set gives no request. A chip erase with every unit protected gives no request. Protected units never appear in `erase_mask_o`.
- R9: `busy_o` rises in the cycle after the request and stays high for exactly `ERASE_CYC_SECT` cycles after a sector erase, or `ERASE_CYC_CHIP` cycles after a chip erase.
- R10: A command during which `busy_o` was high at any cycle while chip select was low gives no request, even if busy has ended by the time chip select rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Local clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sclk_i | input | 1 | Serial clock, mode 0 |
| cs_ni | input | 1 | Chip select, active low |
| mosi_i | input | 1 | Serial data in |
| page_bin_i | input | 1 | 1: 256-byte page layout, 0: 264-byte page layout |
| prot_i | input | 17 | Protection per unit (bit 0 sub-sector a, bit 1 sub-sector b, bit s+1 sector s) |
| erase_req_o | output | 1 | One-cycle erase request |
| erase_chip_o | output | 1 | Request is a chip erase |
| erase_mask_o | output | 17 | Units to erase, valid with the request |
| busy_o | output | 1 | Erase in progress |

## Verification
The inline assertions check on every cycle that the request is a single-cycle pulse, that the mask is idle outside a request and is one-hot for a sector erase, and that no protected unit is ever in the mask. They also check that no request appears while busy and that busy starts right after a request. Which unit a given address selects, in each page layout, is shown only by the bench's scenarios. The same holds for the exact busy length, the rejection of each malformed framing, and the discard of a command that overlapped a busy period. The bench sweeps every sector in both layouts and the sub-sector boundary pages, and computes the expected mask arithmetically.

// File: rtl/flash_erase_pkg.sv
package flash_erase_pkg;
  localparam int unsigned NUM_SECT = 16;
  localparam int unsigned UNITS    = NUM_SECT + 1;
  localparam int unsigned UNIT_W   = $clog2(UNITS);
  localparam int unsigned CMD_BYTES = 4;
  localparam logic [7:0] OP_SECT_ERASE = 8'h7C;

  function automatic logic [7:0] chip_seq_byte(input int unsigned idx);
    case (idx)
      0:       return 8'hC7;
      1:       return 8'h94;
      2:       return 8'h80;
      default: return 8'h9A;
    endcase
  endfunction
endpackage

// File: rtl/spi_byte_rx.sv
module spi_byte_rx (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sclk_i,
  input  logic       cs_ni,
  input  logic       mosi_i,
  output logic       byte_vld_o,
  output logic [7:0] byte_o,
  output logic       partial_o,
  output logic       sel_o,
  output logic       cs_rise_o
);
  logic [1:0] sclk_q, cs_q;
  logic       mosi_q;
  logic [2:0] bit_cnt_q;
  logic [6:0] shift_q;
  logic       sclk_rise;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q <= 2'b00;
      cs_q   <= 2'b11;
      mosi_q <= 1'b0;
    end else begin
      sclk_q <= {sclk_q[0], sclk_i};
      cs_q   <= {cs_q[0], cs_ni};
      mosi_q <= mosi_i;
    end
  end

  assign sclk_rise = sclk_q[0] & ~sclk_q[1];
  assign sel_o     = ~cs_q[0];
  assign cs_rise_o = cs_q[0] & ~cs_q[1];
  assign partial_o = (bit_cnt_q != 3'd0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_cnt_q  <= '0;
      shift_q    <= '0;
      byte_vld_o <= 1'b0;
      byte_o     <= '0;
    end else begin
      byte_vld_o <= 1'b0;
      if (!sel_o) begin
        bit_cnt_q <= '0;
      end else if (sclk_rise) begin
        shift_q   <= {shift_q[5:0], mosi_q};
        bit_cnt_q <= bit_cnt_q + 3'd1;
        if (bit_cnt_q == 3'd7) begin
          byte_vld_o <= 1'b1;
          byte_o     <= {shift_q, mosi_q};
        end
      end
    end
  end

  a_r5_byte_needs_sel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_vld_o |-> $past(sel_o));
endmodule

// File: rtl/erase_cmd_parser.sv
module erase_cmd_parser
  import flash_erase_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             byte_vld_i,
  input  logic [7:0]       byte_i,
  input  logic             partial_i,
  input  logic             sel_i,
  input  logic             cs_rise_i,
  input  logic             busy_i,
  input  logic             page_bin_i,
  input  logic [UNITS-1:0] prot_i,
  output logic             req_o,
  output logic             chip_o,
  output logic [UNITS-1:0] mask_o
);
  logic [7:0]       cmd_q [CMD_BYTES];
  logic [2:0]       cnt_q;
  logic             taint_q;
  logic [3:0]       sect;
  logic [4:0]       sub_off;
  logic [UNIT_W-1:0] unit_idx;
  logic [UNITS-1:0] unit_oh, next_mask;
  logic             is_sect, is_chip, chip_match, fire;

  for (genvar g = 0; g < CMD_BYTES; g++) begin : g_store
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) cmd_q[g] <= '0;
      else if (byte_vld_i && cnt_q == 3'(g)) cmd_q[g] <= byte_i;
    end
  end

  // byte count saturates one past a full command; taint marks overlap with busy
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      taint_q <= 1'b0;
    end else if (!sel_i) begin
      cnt_q   <= '0;
      taint_q <= 1'b0;
    end else begin
      if (byte_vld_i && cnt_q != 3'd5) cnt_q <= cnt_q + 3'd1;
      if (busy_i) taint_q <= 1'b1;
    end
  end

  always_comb begin
    if (page_bin_i) begin
      sect    = cmd_q[1][3:0];
      sub_off = cmd_q[2][7:3];
    end else begin
      sect    = cmd_q[1][4:1];
      sub_off = {cmd_q[1][0], cmd_q[2][7:4]};
    end
    if (sect == 4'd0) unit_idx = {4'd0, (sub_off != 5'd0)};
    else              unit_idx = {1'b0, sect} + 5'd1;
    unit_oh = UNITS'(1) << unit_idx;

    chip_match = 1'b1;
    for (int i = 0; i < CMD_BYTES; i++)
      if (cmd_q[i] != chip_seq_byte(i)) chip_match = 1'b0;

    is_sect = (cnt_q == 3'd4) && !partial_i && (cmd_q[0] == OP_SECT_ERASE);
    is_chip = (cnt_q >= 3'd4) && chip_match;

    if (is_chip)      next_mask = ~prot_i;
    else if (is_sect) next_mask = unit_oh & ~prot_i;
    else              next_mask = '0;

    fire = cs_rise_i && !taint_q && !busy_i && (next_mask != '0);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_o  <= 1'b0;
      chip_o <= 1'b0;
      mask_o <= '0;
    end else begin
      req_o  <= fire;
      chip_o <= fire && is_chip;
      mask_o <= fire ? next_mask : '0;
    end
  end

  a_r5_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |=> !req_o);
  a_r5_sector_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && !chip_o) |-> ($countones(mask_o) == 1));
  a_r1_mask_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_o |-> (mask_o == '0));
  a_r8_no_protected_unit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |-> ((mask_o & $past(prot_i)) == '0));
  a_r5_after_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |-> !sel_i);
endmodule

// File: rtl/erase_busy_timer.sv
module erase_busy_timer #(
  parameter int unsigned CYC_SECT = 1000,
  parameter int unsigned CYC_CHIP = 8000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic chip_i,
  output logic busy_o
);
  localparam int unsigned CYC_MAX = (CYC_CHIP > CYC_SECT) ? CYC_CHIP : CYC_SECT;
  localparam int unsigned CNT_W   = $clog2(CYC_MAX + 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (start_i)       cnt_q <= chip_i ? CNT_W'(CYC_CHIP) : CNT_W'(CYC_SECT);
    else if (cnt_q != '0)   cnt_q <= cnt_q - CNT_W'(1);
  end

  assign busy_o = (cnt_q != '0);

  a_r9_busy_follows_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> busy_o);
  a_r10_start_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !busy_o);
endmodule

// File: rtl/flash_erase_decoder.sv
module flash_erase_decoder
  import flash_erase_pkg::*;
#(
  parameter int unsigned ERASE_CYC_SECT = 1000,
  parameter int unsigned ERASE_CYC_CHIP = 8000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sclk_i,
  input  logic             cs_ni,
  input  logic             mosi_i,
  input  logic             page_bin_i,
  input  logic [UNITS-1:0] prot_i,
  output logic             erase_req_o,
  output logic             erase_chip_o,
  output logic [UNITS-1:0] erase_mask_o,
  output logic             busy_o
);
  logic       byte_vld, partial, sel, cs_rise;
  logic [7:0] rx_byte;

  spi_byte_rx i_rx (
    .clk_i, .rst_ni, .sclk_i, .cs_ni, .mosi_i,
    .byte_vld_o(byte_vld), .byte_o(rx_byte), .partial_o(partial),
    .sel_o(sel), .cs_rise_o(cs_rise)
  );

  erase_cmd_parser i_parser (
    .clk_i, .rst_ni,
    .byte_vld_i(byte_vld), .byte_i(rx_byte), .partial_i(partial),
    .sel_i(sel), .cs_rise_i(cs_rise), .busy_i(busy_o),
    .page_bin_i, .prot_i,
    .req_o(erase_req_o), .chip_o(erase_chip_o), .mask_o(erase_mask_o)
  );

  erase_busy_timer #(.CYC_SECT(ERASE_CYC_SECT), .CYC_CHIP(ERASE_CYC_CHIP)) i_timer (
    .clk_i, .rst_ni, .start_i(erase_req_o), .chip_i(erase_chip_o), .busy_o
  );

  a_r10_no_req_while_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> !erase_req_o);
endmodule

// File: tb/test_flash_erase_decoder.sv
module test_flash_erase_decoder;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 3;
  localparam int CYC_S      = 250;
  localparam int CYC_C      = 400;
  localparam int UNITS      = 17;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0, page_bin = 1'b0;
  logic [UNITS-1:0] prot = '0;
  logic erase_req, erase_chip, busy;
  logic [UNITS-1:0] erase_mask;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_erase_decoder #(.ERASE_CYC_SECT(CYC_S), .ERASE_CYC_CHIP(CYC_C)) i_flash_erase_decoder (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .cs_ni(cs_n), .mosi_i(mosi),
    .page_bin_i(page_bin), .prot_i(prot),
    .erase_req_o(erase_req), .erase_chip_o(erase_chip), .erase_mask_o(erase_mask),
    .busy_o(busy)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      mosi = b[i];
      repeat (HALF) @(negedge clk);
      sclk = 1'b1;
      repeat (HALF) @(negedge clk);
      sclk = 1'b0;
    end
  endtask

  task automatic cmd_open();
    repeat (4) @(negedge clk);
    cs_n = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic cmd_close();
    repeat (6) @(negedge clk);
    check(erase_req == 1'b0, "R5 no request before release", erase_req, 0);
    cs_n = 1'b1;
  endtask

  task automatic send_sector(input logic [23:0] a, input int extra_bytes, input int extra_bits);
    cmd_open();
    send_bits(8'h7C, 8);
    send_bits(a[23:16], 8);
    send_bits(a[15:8], 8);
    send_bits(a[7:0], 8);
    for (int i = 0; i < extra_bytes; i++) send_bits(8'h5A, 8);
    if (extra_bits > 0) send_bits(8'hFF, extra_bits);
    cmd_close();
  endtask

  task automatic expect_erase(input logic [UNITS-1:0] exp_mask, input bit exp_chip,
                              input int cyc, input string tag);
    bit seen = 0;
    logic [UNITS-1:0] m = '0;
    logic c = 1'b0;
    int n = 0;
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      if (erase_req) begin seen = 1; m = erase_mask; c = erase_chip; break; end
    end
    check(seen, {tag, " request issued"}, seen, 1);
    check(m == exp_mask, {tag, " mask"}, m, exp_mask);
    check(c == exp_chip, {tag, " chip flag"}, c, exp_chip);
    for (int k = 0; k < cyc + 20; k++) begin
      @(negedge clk);
      if (busy) n++; else break;
    end
    check(n == cyc, "R9 busy length", n, cyc);
  endtask

  task automatic expect_none(input string tag);
    bit seen = 0;
    bit b = 0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (erase_req) seen = 1;
      if (busy) b = 1;
    end
    check(!seen, {tag, " no request"}, seen, 0);
    check(!b, {tag, " no busy"}, b, 0);
  endtask

  task automatic send_chip(input logic [7:0] last, input int extra_bytes, input int extra_bits);
    cmd_open();
    send_bits(8'hC7, 8);
    send_bits(8'h94, 8);
    send_bits(8'h80, 8);
    send_bits(last, 8);
    for (int i = 0; i < extra_bytes; i++) send_bits(8'h7C, 8);
    if (extra_bits > 0) send_bits(8'hA5, extra_bits);
    cmd_close();
  endtask

  function automatic logic [23:0] make_addr(input bit bin, input int sec, input int pg, input int byt);
    if (bin) return 24'((10 << 20) + (sec << 16) + (pg << 8) + (byt % 256));
    else     return 24'((5 << 21) + ((sec * 256 + pg) << 9) + (byt % 264));
  endfunction

  function automatic logic [UNITS-1:0] unit_mask(input int sec, input int pg);
    int u;
    if (sec == 0) u = (pg < 8) ? 0 : 1;
    else          u = sec + 1;
    return UNITS'(1) << u;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(erase_req == 1'b0, "R1 reset request", erase_req, 0);
    check(busy == 1'b0, "R1 reset busy", busy, 0);
    check(erase_mask == '0, "R1 reset mask", erase_mask, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R2 R3 R4: every sector in both layouts, boundary pages in sector 0
    for (int bin = 0; bin < 2; bin++) begin
      page_bin = bin[0];
      for (int sec = 0; sec < 16; sec++) begin
        for (int pv = 0; pv < ((sec == 0) ? 4 : 2); pv++) begin
          int pg = (pv == 0) ? 0 : (pv == 1) ? 7 : (pv == 2) ? 8 : 255;
          if (sec != 0 && pv == 1) pg = (sec * 37) % 256;
          send_sector(make_addr(bin[0], sec, pg, sec * 29 + pv * 11), 0, 0);
          expect_erase(unit_mask(sec, pg), 1'b0, CYC_S, bin ? "R3 binary sector" : "R2 264 sector");
        end
      end
    end
    // R4 sub-sector split inside the page offset field
    page_bin = 1'b0;
    send_sector(make_addr(1'b0, 0, 16, 3), 0, 0);
    expect_erase(17'h2, 1'b0, CYC_S, "R4 264 page16 sub b");
    page_bin = 1'b1;
    send_sector(make_addr(1'b1, 0, 128, 0), 0, 0);
    expect_erase(17'h2, 1'b0, CYC_S, "R4 bin page128 sub b");

    // R6 chip erase, plain, with extra bytes, with extra bits
    prot = 17'h05A5A;
    send_chip(8'h9A, 0, 0);
    expect_erase(~17'h05A5A, 1'b1, CYC_C, "R6 chip erase");
    prot = 17'h10003;
    send_chip(8'h9A, 2, 0);
    expect_erase(~17'h10003, 1'b1, CYC_C, "R6 chip extra bytes");
    prot = '0;
    send_chip(8'h9A, 1, 5);
    expect_erase('1, 1'b1, CYC_C, "R6 chip extra bits");

    // R7 malformed commands
    page_bin = 1'b0;
    cmd_open(); send_bits(8'h7D, 8); send_bits(8'h02, 8); send_bits(8'h00, 8); send_bits(8'h00, 8); cmd_close();
    expect_none("R7 wrong opcode");
    cmd_open(); send_bits(8'h7C, 8); send_bits(8'h02, 8); send_bits(8'h00, 8); cmd_close();
    expect_none("R7 short sector");
    send_sector(make_addr(1'b0, 3, 0, 0), 1, 0);
    expect_none("R7 sector extra byte");
    send_sector(make_addr(1'b0, 3, 0, 0), 0, 3);
    expect_none("R7 sector extra bits");
    send_chip(8'h9B, 0, 0);
    expect_none("R7 chip wrong byte");
    cmd_open(); send_bits(8'hC7, 8); send_bits(8'h94, 8); send_bits(8'h80, 8); cmd_close();
    expect_none("R7 chip short");

    // R8 protection
    prot = UNITS'(1) << 7;
    send_sector(make_addr(1'b0, 6, 20, 0), 0, 0);
    expect_none("R8 protected sector 6");
    prot = 17'h1;
    send_sector(make_addr(1'b0, 0, 3, 0), 0, 0);
    expect_none("R8 protected sub a");
    send_sector(make_addr(1'b0, 0, 9, 0), 0, 0);
    expect_erase(17'h2, 1'b0, CYC_S, "R8 sub b open");
    prot = '1;
    send_chip(8'h9A, 0, 0);
    expect_none("R8 chip all protected");
    prot = '0;

    // R10 command overlapping busy is discarded
    send_sector(make_addr(1'b0, 3, 0, 0), 0, 0);
    begin
      bit seen = 0;
      for (int k = 0; k < 12 && !seen; k++) begin
        @(negedge clk);
        if (erase_req) seen = 1;
      end
      check(seen, "R10 first request", seen, 1);
      send_sector(make_addr(1'b0, 4, 0, 0), 0, 0);
      seen = 0;
      for (int k = 0; k < CYC_S + 40; k++) begin
        @(negedge clk);
        if (erase_req) seen = 1;
      end
      check(!seen, "R10 command during busy ignored", seen, 0);
      check(busy == 1'b0, "R10 busy ended", busy, 0);
    end
    send_sector(make_addr(1'b0, 4, 0, 0), 0, 0);
    expect_erase(UNITS'(1) << 5, 1'b0, CYC_S, "R10 accepted when idle");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule